// File: doc/BRIEF.md
# Pulse Accumulator with Edge and Overflow Flags

This block is a 16-bit pulse accumulator with two modes. In edge-count mode it counts every selected transition (rising or falling) on one external pin. In gated mode it treats the same pin as a gate and adds one to the count for each prescaler strobe that arrives while the gate is at its active level. The pin passes through a two-flop synchronizer into the bus clock domain. A third flop holds the previous sample so that edges can be detected. Because of this path, a pin change is counted on the third rising clock edge after it happens.

A small register bus gives word access to the count at address 0 and to the flag register at address 1. Flag bit 1 signals a wrap of the count, and flag bit 0 signals an input edge. Both bits are write-one-to-clear. When the fast-clear input is high, any access to the count also clears both flags. Each flag drives its own level interrupt output, gated by its own enable.

A controller with four named states sits at the centre of the block:
- `ST_OFF`: accumulator disabled.
- `ST_EVENT`: edge counting.
- `ST_GATE_SHUT`: gated mode with the gate inactive.
- `ST_GATE_OPEN`: gated mode with the gate active.

The transitions are:
- Any state goes to `ST_OFF` when the enable is low.
- With the enable high, any state goes to `ST_EVENT` when gated mode is off.
- In gated mode, any state goes to `ST_GATE_OPEN` when the synchronized gate is active, and to `ST_GATE_SHUT` otherwise.
- The transition from `ST_GATE_OPEN` to `ST_GATE_SHUT` is the gate's trailing edge. It raises the edge flag.

Top module: `pacc_top`

## Requirements
- R1: After reset the count reads 0, the flag register reads 0 and both interrupt outputs are low.
- R2: In edge-count mode, each selected edge on `pin_in` adds 1 to the count and sets flag bit 0. With `edge_sel`=0 the selected edge is rising; with `edge_sel`=1 it is falling. The opposite edge changes neither the count nor the flags.
- R3: When the count wraps from 0xFFFF to 0x0000, flag bit 1 is set.
- R4: A write to the flag register (address 1) clears flag bit 1 when data bit 1 is 1, and clears flag bit 0 when data bit 0 is 1. A 0 in a data bit leaves the matching flag unchanged.
- R5: In gated mode, the count adds 1 for each `presc_tick` cycle while the synchronized gate is active. The gate is active high when `edge_sel`=0 and active low when `edge_sel`=1. Strobes while the gate is inactive are ignored.
- R6: In gated mode, the trailing edge of the gate (active to inactive) sets flag bit 0. The leading edge does not.
- R7: With `fast_clr`=1, any read or write of the count (address 0) clears both flags. With `fast_clr`=0, count accesses leave the flags unchanged.
- R8: A write to address 0 loads the full 16-bit count in one cycle. It takes priority over an increment in the same cycle.
- R9: `ovf_irq` equals flag bit 1 AND `ovf_ie`, and `edge_irq` equals flag bit 0 AND `edge_ie`.
- R10: With `acc_en`=0, pin activity and strobes change neither the count nor the flags.
- R11: A pin change reaches the count on the third rising clock edge after it. Two edges after the change, the count still holds the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Accumulator enable |
| gated_mode | input | 1 | 1 = gated time accumulation, 0 = edge counting |
| edge_sel | input | 1 | Edge/level polarity: 0 = rising / active high, 1 = falling / active low |
| fast_clr | input | 1 | Clear all flags on any count access |
| presc_tick | input | 1 | Prescaler strobe for gated mode |
| pin_in | input | 1 | External asynchronous input |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = count, 1 = flags |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the address |
| ovf_ie | input | 1 | Overflow interrupt enable |
| edge_ie | input | 1 | Edge interrupt enable |
| ovf_irq | output | 1 | Overflow interrupt request |
| edge_irq | output | 1 | Edge interrupt request |

## Verification
The hardest condition to reach from the ports is the wrap of the count. Counting up from zero through the pin would take 65,536 edges, so the stimulus first loads 0xFFFE over the bus and then drives two selected edges. A write that lands in the same cycle as an increment is also hard to reach. The bench reaches it by placing the write two cycles after a pin change, so that it coincides with the synchronizer's third edge. Randomized runs then mix the pin level and the edge polarity with occasional flag clears against a bench model.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
    typedef enum logic [1:0] {
        ST_OFF,
        ST_EVENT,
        ST_GATE_SHUT,
        ST_GATE_OPEN
    } pacc_state_e;

    localparam logic ADDR_COUNT = 1'b0;
    localparam logic ADDR_FLAGS = 1'b1;
    localparam int   FLAG_W     = 2;
    localparam int   FLG_EDGE   = 0;
    localparam int   FLG_OVF    = 1;
endpackage

// File: rtl/pacc_sync.sv
module pacc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic level_o,
    output logic prev_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= pin_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign level_o = chain_q[STAGES-1];
    assign prev_o  = prev_q;
endmodule

// File: rtl/pacc_fsm.sv
module pacc_fsm
    import pacc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_en,
    input  logic        gated_mode,
    input  logic        gate_act,
    output pacc_state_e state_o,
    output logic        event_en_o,
    output logic        tick_en_o,
    output logic        trail_o
);
    pacc_state_e state_q, state_d;

    always_comb begin
        if (!acc_en)         state_d = ST_OFF;
        else if (!gated_mode) state_d = ST_EVENT;
        else if (gate_act)   state_d = ST_GATE_OPEN;
        else                 state_d = ST_GATE_SHUT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        event_en_o = 1'b0;
        tick_en_o  = 1'b0;
        trail_o    = 1'b0;
        unique case (state_q)
            ST_OFF:       ;
            ST_EVENT:     event_en_o = 1'b1;
            ST_GATE_SHUT: ;
            ST_GATE_OPEN: begin
                tick_en_o = 1'b1;
                trail_o   = (state_d == ST_GATE_SHUT);
            end
            default:      ;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/pacc_counter.sv
module pacc_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (inc)  cnt_q <= cnt_q + 1'b1;
    end

    assign wrap_o = inc && !load && (cnt_q == CNT_MAX);
    assign cnt_o  = cnt_q;
endmodule

// File: rtl/pacc_flags.sv
module pacc_flags
    import pacc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] set_i,
    input  logic [FLAG_W-1:0] clr_i,
    output logic [FLAG_W-1:0] flags_o
);
    logic [FLAG_W-1:0] flags_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~clr_i) | set_i;
    end

    assign flags_o = flags_q;
endmodule

// File: rtl/pacc_top.sv
module pacc_top
    import pacc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_en,
    input  logic             gated_mode,
    input  logic             edge_sel,
    input  logic             fast_clr,
    input  logic             presc_tick,
    input  logic             pin_in,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic             bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    input  logic             ovf_ie,
    input  logic             edge_ie,
    output logic             ovf_irq,
    output logic             edge_irq
);
    logic              lvl_now, lvl_prev;
    logic              act_now, act_prev;
    logic              edge_evt;
    pacc_state_e       st_q;
    logic              event_en, tick_en, trail;
    logic              cnt_acc, cnt_wr, flg_wr;
    logic              inc, wrap;
    logic [CNT_W-1:0]  cnt_q;
    logic [FLAG_W-1:0] set_v, clr_v, flags_q;

    pacc_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (pin_in),
        .level_o (lvl_now),
        .prev_o  (lvl_prev)
    );

    assign act_now  = lvl_now ^ edge_sel;
    assign act_prev = lvl_prev ^ edge_sel;
    assign edge_evt = act_now && !act_prev;

    pacc_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_en     (acc_en),
        .gated_mode (gated_mode),
        .gate_act   (act_now),
        .state_o    (st_q),
        .event_en_o (event_en),
        .tick_en_o  (tick_en),
        .trail_o    (trail)
    );

    assign cnt_acc = bus_sel && (bus_addr == ADDR_COUNT);
    assign cnt_wr  = cnt_acc && bus_wr;
    assign flg_wr  = bus_sel && bus_wr && (bus_addr == ADDR_FLAGS);
    assign inc     = (event_en && edge_evt) || (tick_en && presc_tick);

    pacc_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_wr),
        .load_val (bus_wdata),
        .inc      (inc),
        .cnt_o    (cnt_q),
        .wrap_o   (wrap)
    );

    always_comb begin
        set_v           = '0;
        set_v[FLG_OVF]  = wrap;
        set_v[FLG_EDGE] = (event_en && edge_evt) || trail;
        clr_v           = ({FLAG_W{flg_wr}} & bus_wdata[FLAG_W-1:0])
                        | {FLAG_W{cnt_acc && fast_clr}};
    end

    pacc_flags flags_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (set_v),
        .clr_i   (clr_v),
        .flags_o (flags_q)
    );

    always_comb begin
        if (bus_addr == ADDR_COUNT) bus_rdata = cnt_q;
        else bus_rdata = {{(CNT_W-FLAG_W){1'b0}}, flags_q};
    end

    assign ovf_irq  = flags_q[FLG_OVF] && ovf_ie;
    assign edge_irq = flags_q[FLG_EDGE] && edge_ie;
endmodule

// File: rtl/pacc_chk.sv
module pacc_chk
    import pacc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic             bus_addr,
    input logic [CNT_W-1:0] bus_wdata,
    input logic             fast_clr,
    input logic             ovf_ie,
    input logic             ovf_irq,
    input logic [CNT_W-1:0] cnt_q,
    input logic             ovf_q,
    input pacc_state_e      st_q
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    logic cnt_wr_c, flg_wr_c;
    assign cnt_wr_c = bus_sel && bus_wr && (bus_addr == ADDR_COUNT);
    assign flg_wr_c = bus_sel && bus_wr && (bus_addr == ADDR_FLAGS);

    assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr_c |=> (cnt_q == $past(bus_wdata)));

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_wr_c |=> ((cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1)));

    assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr_c && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX || ovf_q));

    assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flg_wr_c && bus_wdata[FLG_OVF] && cnt_q != CNT_MAX) |=> !ovf_q);

    assert_fast_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_addr == ADDR_COUNT && fast_clr && cnt_q != CNT_MAX) |=> !ovf_q);

    assert_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OFF && !cnt_wr_c) |=> $stable(cnt_q));

    assert_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq |-> ovf_ie);
endmodule

bind pacc_top pacc_chk #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .fast_clr  (fast_clr),
    .ovf_ie    (ovf_ie),
    .ovf_irq   (ovf_irq),
    .cnt_q     (cnt_q),
    .ovf_q     (flags_q[1]),
    .st_q      (st_q)
);

// File: tb/pacc_top_tb_top.sv
`timescale 1ns/1ps
module pacc_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0, gated_mode = 1'b0, edge_sel = 1'b0, fast_clr = 1'b0;
    logic        presc_tick = 1'b0, pin_in = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_addr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        ovf_ie = 1'b0, edge_ie = 1'b0, ovf_irq, edge_irq;

    int          n_chk = 0, n_err = 0;
    logic [15:0] exp_cnt;
    logic        exp_edge;
    logic [15:0] rd;

    always #4 clk = ~clk;

    pacc_top dut_i (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .gated_mode(gated_mode),
        .edge_sel(edge_sel), .fast_clr(fast_clr), .presc_tick(presc_tick),
        .pin_in(pin_in), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ovf_ie(ovf_ie),
        .edge_ie(edge_ie), .ovf_irq(ovf_irq), .edge_irq(edge_irq)
    );

    function automatic logic hit(input logic prev, input logic nw, input logic sel);
        return sel ? (prev && !nw) : (!prev && nw);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic peek(input logic a, output logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step(1);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_held(input logic a);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        step(1);
        bus_sel = 1'b0;
    endtask

    task automatic set_pin(input logic v);
        pin_in = v;
        step(4);
    endtask

    initial begin
        #(8 * 150000);
        n_err++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        step(3);
        rst_n = 1'b1;
        step(1);
        peek(1'b0, rd); chk("R1 count", rd, 0);
        peek(1'b1, rd); chk("R1 flags", rd, 0);
        chk("R1 irqs", {ovf_irq, edge_irq}, 0);

        acc_en = 1'b1; step(2);
        pin_in = 1'b1; step(2);
        peek(1'b0, rd); chk("R11 old count", rd, 0);
        step(1);
        peek(1'b0, rd); chk("R2 rise count", rd, 1);
        peek(1'b1, rd); chk("R2 edge flag", rd, 1);
        set_pin(1'b0);
        peek(1'b0, rd); chk("R2 opposite edge", rd, 1);

        wr(1'b1, 16'h0000);
        peek(1'b1, rd); chk("R4 zero write keeps", rd, 1);
        wr(1'b1, 16'h0001);
        peek(1'b1, rd); chk("R4 clear edge", rd, 0);

        // random edge-count traffic (R2, R4)
        exp_cnt = 16'd1; exp_edge = 1'b0;
        for (int i = 0; i < 60; i++) begin
            logic nw, sel;
            sel = 1'($urandom % 2);
            nw  = 1'($urandom % 2);
            edge_sel = sel; step(1);
            if (hit(pin_in, nw, sel)) begin exp_cnt++; exp_edge = 1'b1; end
            set_pin(nw);
            peek(1'b0, rd); chk("R2 random count", rd, exp_cnt);
            peek(1'b1, rd); chk("R2 random edge flag", rd, {15'b0, exp_edge});
            if ($urandom % 3 == 0) begin
                wr(1'b1, 16'h0001); exp_edge = 1'b0;
                peek(1'b1, rd); chk("R4 random clear", rd, 0);
            end
        end

        // wrap (R3)
        edge_sel = 1'b0;
        if (pin_in) set_pin(1'b0);
        wr(1'b1, 16'h0003);
        wr(1'b0, 16'hFFFE);
        peek(1'b0, rd); chk("R8 load", rd, 16'hFFFE);
        set_pin(1'b1); set_pin(1'b0); set_pin(1'b1);
        peek(1'b0, rd); chk("R3 wrapped count", rd, 0);
        peek(1'b1, rd); chk("R3 ovf flag", rd, 3);

        // interrupts (R9)
        ovf_ie = 1'b1; #1 chk("R9 ovf irq", ovf_irq, 1);
        chk("R9 edge irq masked", edge_irq, 0);
        edge_ie = 1'b1; #1 chk("R9 edge irq", edge_irq, 1);
        step(1);

        wr(1'b1, 16'h0001);
        peek(1'b1, rd); chk("R4 ovf kept", rd, 2);
        wr(1'b1, 16'h0002);
        peek(1'b1, rd); chk("R4 ovf cleared", rd, 0);
        chk("R9 irqs low", {ovf_irq, edge_irq}, 0);

        // write vs same-cycle increment (R8)
        set_pin(1'b0);
        pin_in = 1'b1; step(2);
        wr(1'b0, 16'h1234);
        peek(1'b0, rd); chk("R8 write priority", rd, 16'h1234);
        peek(1'b1, rd); chk("R8 edge still flagged", rd, 1);

        // fast clear (R7)
        fast_clr = 1'b1;
        rd_held(1'b0);
        peek(1'b1, rd); chk("R7 fast clear", rd, 0);
        fast_clr = 1'b0;
        set_pin(1'b0); set_pin(1'b1);
        rd_held(1'b0);
        peek(1'b1, rd); chk("R7 no fast clear", rd, 1);
        wr(1'b1, 16'h0003);

        // disabled (R10)
        acc_en = 1'b0; step(2);
        set_pin(1'b0); set_pin(1'b1); set_pin(1'b0);
        presc_tick = 1'b1; step(3); presc_tick = 1'b0;
        peek(1'b0, rd); chk("R10 count frozen", rd, 16'h1235);
        peek(1'b1, rd); chk("R10 no flags", rd, 0);

        // gated, active high (R5, R6)
        acc_en = 1'b1; gated_mode = 1'b1; edge_sel = 1'b0; step(3);
        wr(1'b0, 16'h0000);
        presc_tick = 1'b1; step(5); presc_tick = 1'b0; step(1);
        peek(1'b0, rd); chk("R5 inactive ticks ignored", rd, 0);
        set_pin(1'b1);
        peek(1'b1, rd); chk("R6 leading edge no flag", rd, 0);
        presc_tick = 1'b1; step(7); presc_tick = 1'b0; step(1);
        peek(1'b0, rd); chk("R5 active-high ticks", rd, 7);
        set_pin(1'b0);
        peek(1'b1, rd); chk("R6 trailing edge flag", rd, 1);
        peek(1'b0, rd); chk("R5 count held", rd, 7);
        wr(1'b1, 16'h0001);

        // gated, active low with random tick count (R5, R6)
        edge_sel = 1'b1; step(4);
        begin
            int n;
            n = 1 + int'($urandom % 20);
            presc_tick = 1'b1; step(n); presc_tick = 1'b0; step(1);
            peek(1'b0, rd); chk("R5 active-low ticks", rd, 7 + n);
            peek(1'b1, rd); chk("R6 no flag while open", rd, 0);
            set_pin(1'b1);
            peek(1'b1, rd); chk("R6 active-low trailing", rd, 1);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule